// File: doc/BRIEF.md
# Dataflow Node Firing Unit

This block is the issue stage of one processing element in a dynamically scheduled dataflow engine. The engine evaluates a fixed, acyclic graph of arithmetic operations. Each incoming token is one flit holding a 64-bit operand value and a 20-bit destination address. The address names a node in this element and one of that node's two operand slots. The unit stores the operand against its node and counts arrivals. When a node's count reaches its configured fan-in, the node goes into a small ready queue. Nodes then leave the queue one at a time. Each node goes to an operator with its operands, in whatever order its data happened to arrive; there is no precomputed schedule.

The operator here is a stub with a fixed pipeline latency. Each result is sent as one outgoing token per entry of the node's fanout list, one token per cycle, with valid/ready flow control toward the network. Per-node settings and the fanout list are written through a configuration port while the unit is idle. A restart strobe clears every arrival count so the same graph can run again with new input tokens.

Top module: `dft_trigger`

## Requirements
- R1: An accepted token writes its value into node `tok_dest[NODE_AW:1]`. Bit `tok_dest[0]` picks operand slot A (0) or B (1). The remaining address bits are ignored.
- R2: A node enters the ready queue on the token that brings its arrival count equal to its fan-in. A node never issues before that. The fan-in bit 0 means one input and 1 means two.
- R3: `tok_ready` is low while the ready queue holds RQ_DEPTH nodes, and no token is taken in such a cycle.
- R4: At most one node is in flight from issue until its last output token. Nodes issue in the order they became ready. A node issues in the cycle after the previous one finishes, or in the cycle after it is queued if the unit is idle.
- R5: The operator result is A+B for opcode 0, A-B for opcode 1, A^B for opcode 2 and A for opcode 3, all taken modulo 2^64. The first output token is valid OP_LAT+1 cycles after the issue cycle.
- R6: A result produces one token per fanout entry, sent one per cycle in the order ptr, ptr+1, … (wrapping at FO_DEPTH). Each token carries the entry's 20-bit address. A length of 0 sends nothing.
- R7: While `out_ready` is low, `out_valid` stays high and the output value and address hold.
- R8: Each node fires at most once per pass. A token for a node whose count already equals its fan-in is dropped.
- R9: `pass_restart` clears all arrival counts. `tok_ready` is low in that cycle. After a restart the graph evaluates again.
- R10: After reset `tok_ready` is 1, `out_valid` is 0 and all arrival counts are zero.
- R11: Configuration writes set a node's fan-in, opcode, fanout pointer and length, and the fanout entries. These take effect for later passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pass_restart | input | 1 | Clear all arrival counts |
| tok_valid | input | 1 | Incoming token valid |
| tok_ready | output | 1 | Incoming token accepted when high |
| tok_value | input | 64 | Incoming operand value |
| tok_dest | input | 20 | Incoming destination address (node, slot) |
| out_valid | output | 1 | Outgoing token valid |
| out_ready | input | 1 | Network can take a token |
| out_value | output | 64 | Outgoing result value |
| out_dest | output | 20 | Outgoing destination address |
| cfg_node_we | input | 1 | Write node settings |
| cfg_node_idx | input | NODE_AW | Node being configured |
| cfg_node_two | input | 1 | Fan-in: 0 one input, 1 two inputs |
| cfg_node_op | input | 2 | Opcode |
| cfg_node_ptr | input | FO_AW | First fanout entry |
| cfg_node_len | input | FO_AW+1 | Number of fanout entries |
| cfg_fo_we | input | 1 | Write fanout entry |
| cfg_fo_idx | input | FO_AW | Fanout entry index |
| cfg_fo_dest | input | 20 | Fanout destination address |

## Verification
Two things can fall on the same clock edge. A token can complete a node, so the ready queue is pushed, while the head node issues, so the queue is popped. The last output token of one node can also hand off to the next issue. The bench provokes both by shuffling input tokens across a mix of one- and two-input nodes, while `out_ready` is held high, toggled at random, or held low until the queue fills. A behavioural reference model built from queues and counters predicts `tok_ready`, `out_valid` and every output token on each clock, so a lost or doubled push or pop shows up as a mismatch.

// File: rtl/dft_pkg.sv
package dft_pkg;
    localparam int VAL_W  = 64;
    localparam int ADDR_W = 20;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_XOR  = 2'd2,
        OP_PASS = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [VAL_W-1:0] a;
        logic [VAL_W-1:0] b;
    } issue_t;

    function automatic logic [VAL_W-1:0] apply_op(input issue_t w);
        case (w.op)
            OP_ADD:  return w.a + w.b;
            OP_SUB:  return w.a - w.b;
            OP_XOR:  return w.a ^ w.b;
            default: return w.a;
        endcase
    endfunction
endpackage

// File: rtl/dft_ready_fifo.sv
module dft_ready_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = slots[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/dft_op_stub.sv
module dft_op_stub
    import dft_pkg::*;
#(
    parameter int LAT   = 3,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  issue_t           in_work,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_value,
    output logic [TAG_W-1:0] out_tag
);
    logic             stg_v   [LAT];
    logic [VAL_W-1:0] stg_val [LAT];
    logic [TAG_W-1:0] stg_tag [LAT];

    always_ff @(posedge clk) begin
        if (rst) stg_v[0] <= 1'b0;
        else     stg_v[0] <= in_valid;
        stg_val[0] <= apply_op(in_work);
        stg_tag[0] <= in_tag;
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_v[s] <= 1'b0;
            else     stg_v[s] <= stg_v[s-1];
            stg_val[s] <= stg_val[s-1];
            stg_tag[s] <= stg_tag[s-1];
        end
    end

    assign out_valid = stg_v[LAT-1];
    assign out_value = stg_val[LAT-1];
    assign out_tag   = stg_tag[LAT-1];
endmodule

// File: rtl/dft_fanout_emitter.sv
module dft_fanout_emitter
    import dft_pkg::*;
#(
    parameter int FO_DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [$clog2(FO_DEPTH)-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0]            cfg_dest,
    input  logic                         load,
    input  logic [VAL_W-1:0]             load_value,
    input  logic [$clog2(FO_DEPTH)-1:0]  load_ptr,
    input  logic [$clog2(FO_DEPTH):0]    load_len,
    output logic                         active,
    output logic                         done,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [VAL_W-1:0]             out_value,
    output logic [ADDR_W-1:0]            out_dest
);
    localparam int FO_AW = $clog2(FO_DEPTH);

    logic [ADDR_W-1:0] fo_mem [FO_DEPTH];
    logic [FO_AW-1:0]  cur;
    logic [FO_AW:0]    left;
    logic              hs;

    assign hs        = active && out_ready;
    assign out_valid = active;
    assign out_dest  = fo_mem[cur];
    assign done      = (hs && left == 1) || (load && load_len == '0);

    always_ff @(posedge clk) begin
        if (cfg_we) fo_mem[cfg_idx] <= cfg_dest;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cur    <= '0;
            left   <= '0;
        end else if (load) begin
            active    <= (load_len != '0);
            cur       <= load_ptr;
            left      <= load_len;
            out_value <= load_value;
        end else if (hs) begin
            cur  <= cur + 1'b1;
            left <= left - 1'b1;
            if (left == 1) active <= 1'b0;
        end
    end
endmodule

// File: rtl/dft_trigger.sv
module dft_trigger
    import dft_pkg::*;
#(
    parameter int NODES    = 16,
    parameter int RQ_DEPTH = 4,
    parameter int FO_DEPTH = 16,
    parameter int OP_LAT   = 3,
    localparam int NODE_AW = $clog2(NODES),
    localparam int FO_AW   = $clog2(FO_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pass_restart,
    input  logic               tok_valid,
    output logic               tok_ready,
    input  logic [63:0]        tok_value,
    input  logic [19:0]        tok_dest,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [63:0]        out_value,
    output logic [19:0]        out_dest,
    input  logic               cfg_node_we,
    input  logic [NODE_AW-1:0] cfg_node_idx,
    input  logic               cfg_node_two,
    input  logic [1:0]         cfg_node_op,
    input  logic [FO_AW-1:0]   cfg_node_ptr,
    input  logic [FO_AW:0]     cfg_node_len,
    input  logic               cfg_fo_we,
    input  logic [FO_AW-1:0]   cfg_fo_idx,
    input  logic [19:0]        cfg_fo_dest
);
    localparam int RQ_CW = $clog2(RQ_DEPTH+1);

    // per-node configuration and state
    logic               nd_two [NODES];
    op_e                nd_op  [NODES];
    logic [FO_AW-1:0]   nd_ptr [NODES];
    logic [FO_AW:0]     nd_len [NODES];
    logic [1:0]         arr_cnt[NODES];
    logic [VAL_W-1:0]   opnd_a [NODES];
    logic [VAL_W-1:0]   opnd_b [NODES];

    logic [NODE_AW-1:0] tk_node;
    logic               tk_slot;
    logic [1:0]         tk_need;
    logic               accept, tk_live, rq_push;
    logic [NODE_AW-1:0] rq_head;
    logic [RQ_CW-1:0]   rq_count;
    logic               rq_full, rq_empty;
    logic               busy, issue, em_done, em_active;
    logic               res_valid;
    logic [VAL_W-1:0]   res_value;
    logic [NODE_AW-1:0] res_tag;
    issue_t             work;

    assign tk_node   = tok_dest[NODE_AW:1];
    assign tk_slot   = tok_dest[0];
    assign tk_need   = nd_two[tk_node] ? 2'd2 : 2'd1;
    assign tok_ready = !rq_full && !pass_restart;
    assign accept    = tok_valid && tok_ready;
    assign tk_live   = accept && (arr_cnt[tk_node] != tk_need);
    assign rq_push   = tk_live && (arr_cnt[tk_node] + 2'd1 == tk_need);
    assign issue     = !rq_empty && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NODES; n++) begin
                nd_two[n] <= 1'b0;
                nd_op[n]  <= OP_PASS;
                nd_ptr[n] <= '0;
                nd_len[n] <= '0;
            end
        end else if (cfg_node_we) begin
            nd_two[cfg_node_idx] <= cfg_node_two;
            nd_op[cfg_node_idx]  <= op_e'(cfg_node_op);
            nd_ptr[cfg_node_idx] <= cfg_node_ptr;
            nd_len[cfg_node_idx] <= cfg_node_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pass_restart) begin
            for (int n = 0; n < NODES; n++) arr_cnt[n] <= '0;
        end else if (tk_live) begin
            arr_cnt[tk_node] <= arr_cnt[tk_node] + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (tk_live) begin
            if (tk_slot) opnd_b[tk_node] <= tok_value;
            else         opnd_a[tk_node] <= tok_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          busy <= 1'b0;
        else if (issue)   busy <= 1'b1;
        else if (em_done) busy <= 1'b0;
    end

    dft_ready_fifo #(.DEPTH(RQ_DEPTH), .W(NODE_AW)) u_rq (
        .clk(clk), .rst(rst),
        .push(rq_push), .push_data(tk_node), .pop(issue),
        .head(rq_head), .count(rq_count), .full(rq_full), .empty(rq_empty)
    );

    assign work.op = nd_op[rq_head];
    assign work.a  = opnd_a[rq_head];
    assign work.b  = opnd_b[rq_head];

    dft_op_stub #(.LAT(OP_LAT), .TAG_W(NODE_AW)) u_op (
        .clk(clk), .rst(rst),
        .in_valid(issue), .in_work(work), .in_tag(rq_head),
        .out_valid(res_valid), .out_value(res_value), .out_tag(res_tag)
    );

    dft_fanout_emitter #(.FO_DEPTH(FO_DEPTH)) u_emit (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_fo_we), .cfg_idx(cfg_fo_idx), .cfg_dest(cfg_fo_dest),
        .load(res_valid), .load_value(res_value),
        .load_ptr(nd_ptr[res_tag]), .load_len(nd_len[res_tag]),
        .active(em_active), .done(em_done),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_value(out_value), .out_dest(out_dest)
    );
endmodule

// File: rtl/dft_trigger_checker.sv
module dft_trigger_checker #(
    parameter int RQ_DEPTH = 4,
    parameter int RQ_CW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tok_valid,
    input logic             tok_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [63:0]      out_value,
    input logic [19:0]      out_dest,
    input logic [RQ_CW-1:0] rq_count,
    input logic             issue,
    input logic             busy,
    input logic             res_valid,
    input logic             em_active
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        rq_count <= RQ_CW'(RQ_DEPTH));

    assert_stall_block_R3: assert property (@(posedge clk) disable iff (rst)
        (rq_count == RQ_CW'(RQ_DEPTH)) |-> !tok_ready);

    assert_issue_gap_R4: assert property (@(posedge clk) disable iff (rst)
        issue |=> !issue);

    assert_single_flight_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !em_active);

    assert_emit_owned_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_dest)));
endmodule

bind dft_trigger dft_trigger_checker #(.RQ_DEPTH(RQ_DEPTH), .RQ_CW(RQ_CW)) u_chk (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_value(out_value),
    .out_dest(out_dest), .rq_count(rq_count), .issue(issue), .busy(busy),
    .res_valid(res_valid), .em_active(em_active)
);

// File: tb/dft_trigger_tb.sv
module dft_trigger_tb;
    localparam int NODES = 16, RQ_DEPTH = 4, FO_DEPTH = 16, OP_LAT = 3;

    logic clk = 0, rst = 1, pass_restart = 0;
    logic tok_valid = 0, tok_ready, out_valid, out_ready = 1;
    logic [63:0] tok_value = 0, out_value;
    logic [19:0] tok_dest = 0, out_dest;
    logic cfg_node_we = 0, cfg_node_two = 0, cfg_fo_we = 0;
    logic [3:0] cfg_node_idx = 0, cfg_node_ptr = 0, cfg_fo_idx = 0;
    logic [1:0] cfg_node_op = 0;
    logic [4:0] cfg_node_len = 0;
    logic [19:0] cfg_fo_dest = 0;

    always #2 clk = ~clk;

    dft_trigger #(.NODES(NODES), .RQ_DEPTH(RQ_DEPTH), .FO_DEPTH(FO_DEPTH), .OP_LAT(OP_LAT)) u_dut (.*);

    int checks = 0, bad = 0, cycles = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // bench-side graph knowledge
    int c_two[16], c_op[16], c_ptr[16], c_len[16];
    logic [19:0] c_fo[16];

    // reference model
    int m_cnt[16];
    logic [63:0] m_a[16], m_b[16];
    int rq[$];
    bit m_busy, e_act, m_acc_last;
    int p_left, p_node, e_node, e_idx;
    logic [63:0] p_val, e_val;
    int out_seen = 0, stall_seen = 0, or_mode = 0;

    function automatic logic [63:0] ref_op(int op, logic [63:0] a, logic [63:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a ^ b;
            default: return a;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            rq.delete();
            m_busy = 0; e_act = 0; p_left = 0; m_acc_last = 0;
        end else begin
            bit mtr, acc, hs, iss;
            mtr = (rq.size() < RQ_DEPTH) && !pass_restart;
            acc = tok_valid && mtr;
            hs  = e_act && out_ready;
            iss = rq.size() > 0 && !m_busy;
            m_acc_last = acc;
            if (hs) begin
                e_idx++;
                if (e_idx == c_len[e_node]) begin e_act = 0; m_busy = 0; end
            end
            if (p_left == 1) begin
                if (c_len[p_node] == 0) m_busy = 0;
                else begin e_act = 1; e_idx = 0; e_node = p_node; e_val = p_val; end
            end
            if (p_left > 0) p_left--;
            if (iss) begin
                p_node = rq.pop_front();
                p_val  = ref_op(c_op[p_node], m_a[p_node], m_b[p_node]);
                p_left = OP_LAT;
                m_busy = 1;
            end
            if (pass_restart) begin
                foreach (m_cnt[i]) m_cnt[i] = 0;
            end else if (acc) begin
                int nd, need;
                nd = int'(tok_dest[4:1]);
                need = c_two[nd] ? 2 : 1;
                if (m_cnt[nd] != need) begin
                    if (tok_dest[0]) m_b[nd] = tok_value; else m_a[nd] = tok_value;
                    m_cnt[nd]++;
                    if (m_cnt[nd] == need) rq.push_back(nd);
                end
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            bit mtr;
            mtr = (rq.size() < RQ_DEPTH) && !pass_restart;
            check(tok_ready == mtr, "R3 R9 tok_ready", 64'(tok_ready), 64'(mtr));
            check(out_valid == e_act, "R2 R4 R5 out_valid", 64'(out_valid), 64'(e_act));
            if (e_act && out_valid) begin
                logic [19:0] ed;
                ed = c_fo[(c_ptr[e_node] + e_idx) % FO_DEPTH];
                check(out_dest == ed, "R6 R11 out_dest", 64'(out_dest), 64'(ed));
                check(out_value == e_val, "R1 R5 out_value", out_value, e_val);
            end
            if (out_valid && out_ready) out_seen++;
            if (tok_valid && !tok_ready) stall_seen++;
        end
    end

    // out_ready driver: 0 always ready, 1 random, 2 held low
    initial forever begin
        @(posedge clk); #1;
        out_ready = (or_mode == 0) ? 1'b1 : (or_mode == 2) ? 1'b0 : 1'($urandom_range(0, 1));
    end

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                check(0, "watchdog expired", 64'(cycles), 64'd100000);
                $display("test done: total=%0d bad=%0d", checks, bad);
                $finish;
            end
        end
    end

    task automatic cfg_node(int n, int two, int op, int ptr, int len);
        @(posedge clk); #1;
        cfg_node_we = 1; cfg_node_idx = 4'(n); cfg_node_two = 1'(two);
        cfg_node_op = 2'(op); cfg_node_ptr = 4'(ptr); cfg_node_len = 5'(len);
        c_two[n] = two; c_op[n] = op; c_ptr[n] = ptr; c_len[n] = len;
        @(posedge clk); #1;
        cfg_node_we = 0;
    endtask

    task automatic cfg_fo(int i, logic [19:0] d);
        @(posedge clk); #1;
        cfg_fo_we = 1; cfg_fo_idx = 4'(i); cfg_fo_dest = d; c_fo[i] = d;
        @(posedge clk); #1;
        cfg_fo_we = 0;
    endtask

    task automatic send(int n, int slot, logic [63:0] v);
        @(posedge clk); #1;
        tok_valid = 1; tok_dest = 20'((n << 1) | slot) | 20'hF0000; tok_value = v;
        do begin @(posedge clk); #1; end while (!m_acc_last);
        tok_valid = 0;
    endtask

    task automatic restart();
        @(posedge clk); #1;
        pass_restart = 1;
        @(negedge clk);
        check(tok_ready == 0, "R9 tok_ready during restart", 64'(tok_ready), 64'd0);
        @(posedge clk); #1;
        pass_restart = 0;
    endtask

    task automatic drain();
        int quiet = 0;
        while (quiet < 8) begin
            @(posedge clk); #1;
            if (!e_act && !m_busy && rq.size() == 0) quiet++; else quiet = 0;
        end
    endtask

    task automatic run_pass(logic [63:0] base);
        int tn[10], ts[10];
        logic [63:0] tv[10];
        int k = 0;
        for (int n = 0; n < 6; n++) begin
            for (int s = 0; s < (c_two[n] ? 2 : 1); s++) begin
                tn[k] = n; ts[k] = s; tv[k] = base * 64'(n + 3) + 64'(s * 977 + 11); k++;
            end
        end
        for (int i = k - 1; i > 0; i--) begin
            int j, t0, t1; logic [63:0] t2;
            j = $urandom_range(0, i);
            t0 = tn[i]; tn[i] = tn[j]; tn[j] = t0;
            t1 = ts[i]; ts[i] = ts[j]; ts[j] = t1;
            t2 = tv[i]; tv[i] = tv[j]; tv[j] = t2;
        end
        for (int i = 0; i < k; i++) send(tn[i], ts[i], tv[i]);
        drain();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(tok_ready == 1, "R10 reset tok_ready", 64'(tok_ready), 64'd1);
        check(out_valid == 0, "R10 reset out_valid", 64'(out_valid), 64'd0);

        // graph: fanout table and six nodes (R11)
        for (int i = 0; i < 16; i++) cfg_fo(i, 20'hA0000 + 20'(i * 37));
        cfg_node(0, 1, 0, 0, 2);
        cfg_node(1, 1, 1, 2, 1);
        cfg_node(2, 0, 3, 3, 3);
        cfg_node(3, 1, 2, 6, 1);
        cfg_node(4, 0, 3, 7, 0);
        cfg_node(5, 1, 0, 15, 2);

        // pass 1: random order, network always ready (R2 R5 R6)
        or_mode = 0; out_seen = 0;
        run_pass(64'h1234_5678_9ABC_DEF0);
        check(out_seen == 9, "R6 R8 tokens in pass 1", 64'(out_seen), 64'd9);

        // extra token to a fired node is dropped (R8)
        out_seen = 0;
        send(0, 0, 64'hDEAD);
        repeat (20) @(posedge clk);
        check(out_seen == 0, "R8 token after firing", 64'(out_seen), 64'd0);

        // pass 2 after restart, network toggling (R7 R9)
        restart();
        or_mode = 1; out_seen = 0;
        run_pass(64'h0F0F_0000_1111_2222);
        check(out_seen == 9, "R9 R7 tokens in pass 2", 64'(out_seen), 64'd9);

        // backpressure: network stalled, queue fills (R3 R4)
        restart();
        for (int n = 8; n < 14; n++) cfg_node(n, 0, 3, 8, 1);
        or_mode = 2; out_seen = 0; stall_seen = 0;
        for (int n = 8; n < 13; n++) send(n, 0, 64'(n * 1000));
        fork
            send(13, 0, 64'd13013);
            begin repeat (30) @(posedge clk); #1 or_mode = 0; end
        join
        drain();
        check(stall_seen > 0, "R3 tok_ready low on full queue", 64'(stall_seen), 64'd1);
        check(out_seen == 6, "R4 all queued nodes issued", 64'(out_seen), 64'd6);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule